// File: doc/BRIEF.md
# Multi-channel Sample Address Sequencer

This block generates sample-memory byte addresses for six independent playback channels. A host port writes a key register and per-channel start and stop page registers. A page is 256 bytes, so each 16-bit page value sits in bits 23..8 of the 24-bit byte address. A key write starts or stops any subset of the channels. A started channel walks its byte address upward from the first byte of its start page to the last byte of its stop page.

A fixed round-robin slot counter visits channels 0 to 5, one per clock cycle. When a slot belongs to an active channel, that channel issues one registered read request and advances its address. On its final byte the channel goes idle and raises a one-cycle end event. Slots of idle channels produce no request. Sample decoding, gain, panning and mixing lie outside this block.

Top module: `sample_addr_seq`

## Requirements
- R1: After reset, `mem_rd_valid`, `chan_busy` and `chan_end` are 0, and every page register holds 0. A start with no page writes therefore reads bytes 0x000000 to 0x0000FF.
- R2: A write to register 0x00 with bit 7 = 0 starts every channel i whose bit i (bits 5..0) is set. Channels whose bit is clear keep their state.
- R3: A write to register 0x00 with bit 7 = 1 stops every selected channel. No request from that channel appears after the write's clock edge, `chan_busy[i]` drops at that edge, and no end event is raised.
- R4: For channel i, register 0x10+i holds the start page low byte, 0x18+i the start page high byte, 0x20+i the stop page low byte and 0x28+i the stop page high byte.
- R5: The first request of a started channel has address {start_page, 0x00}. Each later request of that channel is one byte higher.
- R6: The last request of a channel has address {stop_page, 0xFF}. `chan_end[i]` is high in exactly the cycle that request is presented, and `chan_busy[i]` is already low in that cycle.
- R7: Slots visit channels 0..5 in order, one slot per cycle. An active channel is therefore served exactly every 6 cycles. Slots of idle channels issue nothing. A key write that selects a channel suppresses that channel's request in the same cycle.
- R8: A start command to a channel that is already playing reloads its address from the current start page.
- R9: The stop page is captured at start. Rewriting the stop or start registers while a channel plays does not change its address sequence until the next start.
- R10: A request is presented on `mem_rd_valid`/`mem_rd_addr`/`mem_rd_chan` one cycle after its channel's slot. `mem_rd_chan` names the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register index |
| host_data | input | 8 | Host write data |
| mem_rd_valid | output | 1 | Read request present this cycle |
| mem_rd_addr | output | 24 | Byte address of the request |
| mem_rd_chan | output | 3 | Channel that issued the request |
| chan_busy | output | 6 | Per-channel playing state |
| chan_end | output | 6 | One-cycle end event per channel |

## Verification
A key write clocked at edge E changes `chan_busy` at E. The first request it causes is presented in the cycle after the channel's next slot, which is 1 to 6 cycles after E. Every later request of that channel follows exactly 6 cycles after the previous one, and the end event shares the cycle of the final request. The bench updates its expected per-channel address queues right after edge E, and samples requests on falling edges. A request from a stopped channel therefore finds an empty queue, and the spacing and end-event checks fall on the exact cycle the timing rules name.

// File: rtl/sas_pkg.sv
package sas_pkg;
  localparam int PAGE_W = 16;
  localparam int OFS_W  = 8;
  localparam int ADDR_W = PAGE_W + OFS_W;

  localparam logic [7:0] KEY_REG   = 8'h00;
  localparam logic [7:0] STLO_BASE = 8'h10;
  localparam logic [7:0] STHI_BASE = 8'h18;
  localparam logic [7:0] SPLO_BASE = 8'h20;
  localparam logic [7:0] SPHI_BASE = 8'h28;
  localparam int         KEY_POL   = 7;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // first byte of a page
  function automatic addr_t page_first(input page_t pg);
    return {pg, {OFS_W{1'b0}}};
  endfunction

  // last byte of a page
  function automatic addr_t page_final(input page_t pg);
    return {pg, {OFS_W{1'b1}}};
  endfunction
endpackage

// File: rtl/sas_regs.sv
module sas_regs
  import sas_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [7:0]                  addr,
  input  logic [7:0]                  data,
  output logic [NCH-1:0][PAGE_W-1:0]  start_pg,
  output logic [NCH-1:0][PAGE_W-1:0]  stop_pg,
  output logic [NCH-1:0]              key_on,
  output logic [NCH-1:0]              key_off
);
  logic key_hit;
  assign key_hit = we && (addr == KEY_REG);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [7:0] IDX = 8'(i);
    logic [7:0] st_lo, st_hi, sp_lo, sp_hi;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_lo <= '0;
        st_hi <= '0;
        sp_lo <= '0;
        sp_hi <= '0;
      end else if (we) begin
        if (addr == STLO_BASE + IDX) st_lo <= data;
        if (addr == STHI_BASE + IDX) st_hi <= data;
        if (addr == SPLO_BASE + IDX) sp_lo <= data;
        if (addr == SPHI_BASE + IDX) sp_hi <= data;
      end
    end

    assign start_pg[i] = {st_hi, st_lo};
    assign stop_pg[i]  = {sp_hi, sp_lo};
    assign key_on[i]   = key_hit && data[i] && !data[KEY_POL];
    assign key_off[i]  = key_hit && data[i] &&  data[KEY_POL];
  end

  // R2/R3: one key write never both starts and stops a channel
  a_r2_key_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (key_on & key_off) == '0);
endmodule

// File: rtl/sas_chan.sv
module sas_chan
  import sas_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  key_on,
  input  logic  key_off,
  input  logic  slot_hit,
  input  page_t start_pg,
  input  page_t stop_pg,
  output logic  busy,
  output addr_t cur_addr,
  output logic  fire,
  output logic  last
);
  logic  busy_q;
  addr_t addr_q;
  page_t stop_q;

  // a key write to this channel takes the slot away (R7)
  assign fire     = slot_hit && busy_q && !key_on && !key_off;
  assign last     = fire && (addr_q == page_final(stop_q));
  assign busy     = busy_q;
  assign cur_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      stop_q <= '0;
    end else if (key_on) begin
      busy_q <= 1'b1;
      addr_q <= page_first(start_pg);
      stop_q <= stop_pg;
    end else if (key_off) begin
      busy_q <= 1'b0;
    end else if (fire) begin
      if (last) busy_q <= 1'b0;
      else      addr_q <= addr_q + 1'b1;
    end
  end

  a_r3_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    key_off |=> !busy_q);
  a_r8_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |=> busy_q && addr_q == page_first($past(start_pg)));
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> addr_q == $past(addr_q) + 1'b1);
  a_r6_final_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> !busy_q);
  a_r9_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
    !key_on |=> stop_q == $past(stop_q));
endmodule

// File: rtl/sas_arb.sv
module sas_arb
  import sas_pkg::*;
#(
  parameter int NCH = 6,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCH-1:0]              fire,
  input  logic [NCH-1:0]              last,
  input  logic [NCH-1:0][ADDR_W-1:0]  addr,
  output logic [NCH-1:0]              slot_hit,
  output logic                        rd_valid,
  output addr_t                       rd_addr,
  output logic [CW-1:0]               rd_chan,
  output logic [NCH-1:0]              end_evt
);
  localparam logic [CW-1:0] SLOT_MAX = CW'(NCH - 1);

  logic [CW-1:0] slot_q;
  logic          sel_fire;
  addr_t         sel_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 slot_q <= '0;
    else if (slot_q == SLOT_MAX) slot_q <= '0;
    else                        slot_q <= slot_q + 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign slot_hit[i] = (slot_q == CW'(i));
  end

  always_comb begin
    sel_fire = 1'b0;
    sel_addr = '0;
    for (int i = 0; i < NCH; i++) begin
      if (slot_hit[i]) begin
        sel_fire = fire[i];
        sel_addr = addr[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      rd_chan  <= '0;
      end_evt  <= '0;
    end else begin
      rd_valid <= sel_fire;
      rd_addr  <= sel_addr;
      rd_chan  <= slot_q;
      end_evt  <= fire & last;
    end
  end

  a_r7_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q == SLOT_MAX |=> slot_q == '0);
  a_r7_slot_next: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q != SLOT_MAX |=> slot_q == $past(slot_q) + 1'b1);
  a_r7_one_end: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(end_evt));
  a_r10_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_chan <= SLOT_MAX);
endmodule

// File: rtl/sample_addr_seq.sv
module sample_addr_seq
  import sas_pkg::*;
#(
  parameter int NCH = 6,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [7:0]        host_addr,
  input  logic [7:0]        host_data,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [CW-1:0]     mem_rd_chan,
  output logic [NCH-1:0]    chan_busy,
  output logic [NCH-1:0]    chan_end
);
  logic [NCH-1:0][PAGE_W-1:0] start_pg, stop_pg;
  logic [NCH-1:0]             key_on, key_off, slot_hit, fire, last;
  logic [NCH-1:0][ADDR_W-1:0] ch_addr;

  sas_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr), .data(host_data),
    .start_pg(start_pg), .stop_pg(stop_pg), .key_on(key_on), .key_off(key_off)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    sas_chan u_chan (
      .clk(clk), .rst_n(rst_n), .key_on(key_on[i]), .key_off(key_off[i]),
      .slot_hit(slot_hit[i]), .start_pg(start_pg[i]), .stop_pg(stop_pg[i]),
      .busy(chan_busy[i]), .cur_addr(ch_addr[i]), .fire(fire[i]), .last(last[i])
    );
  end

  sas_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .fire(fire), .last(last), .addr(ch_addr),
    .slot_hit(slot_hit), .rd_valid(mem_rd_valid), .rd_addr(mem_rd_addr),
    .rd_chan(mem_rd_chan), .end_evt(chan_end)
  );

  // R6: end event rides on the final request, channel already idle
  a_r6_end_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_end) |-> mem_rd_valid && chan_end[mem_rd_chan] && !chan_busy[mem_rd_chan]);
  // R3: a stopped channel raises no end event
  a_r3_no_end_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (|key_off) |=> (chan_end & $past(key_off)) == '0);
endmodule

// File: tb/sample_addr_seq_tb_top.sv
module sample_addr_seq_tb_top;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [7:0]  host_data = '0;
  logic        mem_rd_valid;
  logic [23:0] mem_rd_addr;
  logic [2:0]  mem_rd_chan;
  logic [5:0]  chan_busy;
  logic [5:0]  chan_end;

  sample_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_chan(mem_rd_chan), .chan_busy(chan_busy), .chan_end(chan_end)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  logic [23:0] exp_q [NCH][$];
  int          last_cyc [NCH];
  logic [15:0] m_start [NCH];
  logic [15:0] m_stop  [NCH];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // driver: host write; the scoreboard is updated right after the write's edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_data = d;
    @(posedge clk); #1;
    for (int i = 0; i < NCH; i++) begin
      if (a == 8'h10 + i) m_start[i][7:0]  = d;   // R4
      if (a == 8'h18 + i) m_start[i][15:8] = d;
      if (a == 8'h20 + i) m_stop[i][7:0]   = d;
      if (a == 8'h28 + i) m_stop[i][15:8]  = d;
      if (a == 8'h00 && d[i]) begin
        exp_q[i].delete();
        last_cyc[i] = -1;
        if (!d[7]) begin
          for (int b = int'(m_start[i]) * 256; b <= int'(m_stop[i]) * 256 + 255; b++)
            exp_q[i].push_back(24'(b));
        end
      end
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_pages(input int ch, input logic [15:0] s, input logic [15:0] e);
    wr(8'h10 + 8'(ch), s[7:0]);
    wr(8'h18 + 8'(ch), s[15:8]);
    wr(8'h20 + 8'(ch), e[7:0]);
    wr(8'h28 + 8'(ch), e[15:8]);
  endtask

  task automatic drain();
    int guard = 0;
    bit empty = 0;
    while (!empty && guard < 20000) begin
      @(negedge clk);
      guard++;
      empty = 1;
      for (int i = 0; i < NCH; i++) if (exp_q[i].size() != 0) empty = 0;
    end
    chk(empty, "R6 all sequences complete", 32'(guard), 32'd0);
    @(negedge clk);
    chk(chan_busy == 6'b0, "R6 channels idle after final byte", 32'(chan_busy), 32'd0);
  endtask

  // monitor: pops expected addresses as requests appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_rd_valid) begin
        int ch;
        ch = int'(mem_rd_chan);
        if (ch >= NCH || exp_q[ch].size() == 0) begin
          chk(0, "R3/R7 unexpected request", {5'd0, mem_rd_chan, mem_rd_addr}, 32'hFFFFFFFF);
        end else begin
          logic [23:0] e;
          e = exp_q[ch].pop_front();
          chk(mem_rd_addr == e, "R5 request address", 32'(mem_rd_addr), 32'(e));
          if (last_cyc[ch] >= 0)
            chk(cyc - last_cyc[ch] == NCH, "R7 service spacing", 32'(cyc - last_cyc[ch]), 32'(NCH));
          last_cyc[ch] = cyc;
          chk(chan_end == ((exp_q[ch].size() == 0) ? (6'b1 << ch) : 6'b0),
              "R6 end event with final request", 32'(chan_end),
              32'((exp_q[ch].size() == 0) ? (6'b1 << ch) : 6'b0));
        end
      end else if (chan_end != 6'b0) begin
        chk(0, "R6 end event without request", 32'(chan_end), 32'd0);
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 32'(cyc), 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_start[i] = '0; m_stop[i] = '0; last_cyc[i] = -1;
    end
    repeat (3) @(negedge clk);
    chk(mem_rd_valid == 1'b0, "R1 reset request idle", 32'(mem_rd_valid), 32'd0);
    chk(chan_busy == 6'b0, "R1 reset busy", 32'(chan_busy), 32'd0);
    chk(chan_end == 6'b0, "R1 reset end", 32'(chan_end), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset pages are zero -> 0x000000..0x0000FF
    wr(8'h00, 8'h01);
    chk(chan_busy == 6'b000001, "R2 start channel 0", 32'(chan_busy), 32'h01);
    drain();

    // R4/R5/R6/R7: three channels interleaved, incl. top of address space
    set_pages(1, 16'h0102, 16'h0103);
    set_pages(4, 16'hABCD, 16'hABCD);
    set_pages(5, 16'hFFFF, 16'hFFFF);
    wr(8'h00, 8'h32);
    chk(chan_busy == 6'b110010, "R2 start subset", 32'(chan_busy), 32'h32);
    drain();

    // R2/R3: start ch2, then ch3 leaves ch2 running, then stop ch2 only
    set_pages(2, 16'h0010, 16'h0011);
    set_pages(3, 16'h0020, 16'h0020);
    wr(8'h00, 8'h04);
    repeat (30) @(negedge clk);
    wr(8'h00, 8'h08);
    chk(chan_busy == 6'b001100, "R2 unselected channel unaffected", 32'(chan_busy), 32'h0C);
    repeat (20) @(negedge clk);
    wr(8'h00, 8'h84);
    chk(chan_busy == 6'b001000, "R3 stop selected only", 32'(chan_busy), 32'h08);
    drain();

    // R8/R9: page rewrite while playing has no effect; restart reloads
    set_pages(0, 16'h0040, 16'h0041);
    wr(8'h00, 8'h01);
    repeat (50) @(negedge clk);
    set_pages(0, 16'h0050, 16'h0050);
    chk(chan_busy[0] == 1'b1, "R9 still playing after rewrite", 32'(chan_busy), 32'h01);
    repeat (20) @(negedge clk);
    wr(8'h00, 8'h01);
    drain();

    // R3: stop all channels mid-play; nothing further may appear
    wr(8'h00, 8'h3F);
    repeat (40) @(negedge clk);
    wr(8'h00, 8'hBF);
    chk(chan_busy == 6'b0, "R3 stop all", 32'(chan_busy), 32'd0);
    repeat (30) @(negedge clk);
    chk(chan_busy == 6'b0, "R3 stay idle", 32'(chan_busy), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule